// File: doc/BRIEF.md
# ADC Code Histogram Tally

This block watches the stream of 3-bit codes from one ADC channel and counts how often each code value appears within an integration window. Software or a tuning loop uses the histogram to adjust the converter's gain and offset so that the codes are spread sensibly across the range. Seven counters cover codes 0 through 6. A separate counter counts every valid sample. The count for code 7 is the total minus the seven bins, so it needs no counter of its own.

The window length is a programmable number of clocks. When a window closes, every bin and the total are copied into holding registers in a single clock, and a one-clock done pulse is raised. The live counters restart at once. The sample that arrives on the closing clock is already counted in the new window, so no sample is lost. A read port selects one held bin at a time. Counters saturate instead of wrapping, and a sticky flag records that saturation happened.

Top module: `adcCodeTally`

## Requirements
- R1: While reset (rstN low) is applied and after it is released, every held bin, heldTotal, periodDone and overflowFlag read zero until the first window closes.
- R2: A clock with sampleValid high and sampleCode equal to c (0..6) adds one to live bin c. A clock with sampleValid low adds to no bin and not to the total.
- R3: The total counts every valid sample, including code 7. Reading rdAddr = 7 returns the held total minus the sum of held bins 0..6, which equals the number of code-7 samples while no bin has saturated.
- R4: A window counter advances on every clock from 0 after reset. The clock on which it equals periodLen-1 is a boundary, and the counter returns to 0 after it. A periodLen of 0 or 1 makes every clock a boundary.
- R5: On a boundary clock, all live bins and the live total move into the holding registers, which are visible from the next clock. The held values do not change until the next boundary.
- R6: The sample presented on a boundary clock is counted in the new window: its live bin and the live total restart at 1 rather than 0.
- R7: periodDone is high for exactly one clock after each boundary, in the same clock that the new held values first appear.
- R8: A bin or the total that has reached its maximum value stays at that value on further hits. Any such lost hit sets overflowFlag, which stays set until reset.
- R9: rdData shows held bin rdAddr for addresses 0..6 combinationally, with no clock of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | Sample qualifier |
| sampleCode | input | CODE_W | ADC output code |
| periodLen | input | PERIOD_W | Window length in clocks |
| rdAddr | input | CODE_W | Held bin select; 7 selects the derived code-7 bin |
| rdData | output | BIN_W | Selected held bin |
| heldTotal | output | BIN_W+CODE_W | Held count of valid samples |
| periodDone | output | 1 | One-clock pulse after each boundary |
| overflowFlag | output | 1 | Sticky saturation indicator |

## Verification
A window's held results appear one clock after its boundary clock, which is the clock that carries the first sample of the following window. The bench therefore checks each window's eight bins at the falling edge after that clock. At the next falling edge it checks that periodDone has dropped and that the held values have not moved. The read port is combinational, so each address is set and read a nanosecond later within the same low phase. The saturation and every-clock-boundary cases are directed runs, and their expected values are counted clock by clock from reset release.

// File: rtl/tallyPkg.sv
package tallyPkg;
  // Strobes issued by the window control to the counting datapath
  typedef struct packed {
    logic snap;  // boundary clock: latch and restart
    logic take;  // current sample is valid
  } strobeT;
endpackage

// File: rtl/tallyCtrl.sv
module tallyCtrl
  import tallyPkg::*;
#(
  parameter int PERIOD_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [PERIOD_W-1:0] periodLen,
  output strobeT              stb,
  output logic                periodDone
);
  logic [PERIOD_W-1:0] cycleCnt;
  logic                boundary;

  // counter+1 reaching the length closes the window; 0 and 1 close every clock
  assign boundary = ({1'b0, cycleCnt} + (PERIOD_W+1)'(1)) >= {1'b0, periodLen};

  always_comb begin
    stb.snap = boundary;
    stb.take = sampleValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycleCnt   <= '0;
      periodDone <= 1'b0;
    end else begin
      cycleCnt   <= boundary ? '0 : cycleCnt + 1'b1;
      periodDone <= boundary;
    end
  end

  assert_restart_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.snap |=> cycleCnt == '0);

  assert_advance_R4: assert property (@(posedge clk) disable iff (!rstN)
    !stb.snap |=> cycleCnt == PERIOD_W'($past(cycleCnt) + 1'b1));

  assert_done_follows_R7: assert property (@(posedge clk) disable iff (!rstN)
    !stb.snap |=> !periodDone);
endmodule

// File: rtl/tallyData.sv
module tallyData
  import tallyPkg::*;
#(
  parameter int CODE_W  = 3,
  parameter int BIN_W   = 29,
  parameter int TOTAL_W = BIN_W + CODE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             stb,
  input  logic [CODE_W-1:0]  sampleCode,
  input  logic [CODE_W-1:0]  rdAddr,
  input  logic               periodDone,
  output logic [BIN_W-1:0]   rdData,
  output logic [TOTAL_W-1:0] heldTotal,
  output logic               overflowFlag
);
  localparam int NUM_BINS = (1 << CODE_W) - 1;
  localparam logic [BIN_W-1:0]   BIN_MAX = '1;
  localparam logic [TOTAL_W-1:0] TOT_MAX = '1;

  logic [BIN_W-1:0]   liveBin [NUM_BINS];
  logic [BIN_W-1:0]   heldBin [NUM_BINS];
  logic [NUM_BINS-1:0] binLost;
  logic [TOTAL_W-1:0] liveTotal;
  logic               totLost;
  logic [TOTAL_W-1:0] heldSum;
  logic [TOTAL_W-1:0] derivedFull;
  logic [BIN_W-1:0]   derivedBin;

  for (genvar g = 0; g < NUM_BINS; g++) begin : gBin
    logic hit;
    assign hit        = stb.take && (sampleCode == CODE_W'(g));
    assign binLost[g] = hit && !stb.snap && (liveBin[g] == BIN_MAX);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        liveBin[g] <= '0;
        heldBin[g] <= '0;
      end else if (stb.snap) begin
        heldBin[g] <= liveBin[g];
        liveBin[g] <= {{(BIN_W-1){1'b0}}, hit};
      end else if (hit && liveBin[g] != BIN_MAX) begin
        liveBin[g] <= liveBin[g] + 1'b1;
      end
    end
  end

  assign totLost = stb.take && !stb.snap && (liveTotal == TOT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      liveTotal    <= '0;
      heldTotal    <= '0;
      overflowFlag <= 1'b0;
    end else begin
      overflowFlag <= overflowFlag | (|binLost) | totLost;
      if (stb.snap) begin
        heldTotal <= liveTotal;
        liveTotal <= {{(TOTAL_W-1){1'b0}}, stb.take};
      end else if (stb.take && liveTotal != TOT_MAX) begin
        liveTotal <= liveTotal + 1'b1;
      end
    end
  end

  // code 2^CODE_W-1 is the remainder of the total
  always_comb begin
    heldSum = '0;
    for (int i = 0; i < NUM_BINS; i++) heldSum = heldSum + TOTAL_W'(heldBin[i]);
    derivedFull = (heldTotal >= heldSum) ? heldTotal - heldSum : '0;
    derivedBin  = (derivedFull > TOTAL_W'(BIN_MAX)) ? BIN_MAX : derivedFull[BIN_W-1:0];
  end

  always_comb begin
    rdData = derivedBin;
    for (int i = 0; i < NUM_BINS; i++)
      if (rdAddr == CODE_W'(i)) rdData = heldBin[i];
  end

  assert_held_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    !periodDone |-> $stable(heldTotal));

  assert_sum_bounded_R3: assert property (@(posedge clk) disable iff (!rstN)
    heldSum <= heldTotal);

  assert_sticky_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag |=> overflowFlag);

  assert_restart_one_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.snap && stb.take) |=> liveTotal == TOTAL_W'(1));
endmodule

// File: rtl/adcCodeTally.sv
module adcCodeTally
  import tallyPkg::*;
#(
  parameter int CODE_W   = 3,
  parameter int BIN_W    = 29,
  parameter int PERIOD_W = 32,
  localparam int TOTAL_W = BIN_W + CODE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [CODE_W-1:0]   sampleCode,
  input  logic [PERIOD_W-1:0] periodLen,
  input  logic [CODE_W-1:0]   rdAddr,
  output logic [BIN_W-1:0]    rdData,
  output logic [TOTAL_W-1:0]  heldTotal,
  output logic                periodDone,
  output logic                overflowFlag
);
  strobeT stb;

  tallyCtrl #(.PERIOD_W(PERIOD_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .periodLen(periodLen), .stb(stb), .periodDone(periodDone)
  );

  tallyData #(.CODE_W(CODE_W), .BIN_W(BIN_W), .TOTAL_W(TOTAL_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .sampleCode(sampleCode),
    .rdAddr(rdAddr), .periodDone(periodDone), .rdData(rdData),
    .heldTotal(heldTotal), .overflowFlag(overflowFlag)
  );
endmodule

// File: tb/sim_adcCodeTally.sv
module sim_adcCodeTally;
  localparam int CLK_PERIOD = 20;
  localparam int BIN_W = 6;
  localparam int PERIOD_W = 8;
  localparam int TOTAL_W = BIN_W + 3;
  localparam int LEN = 10;

  typedef struct packed {
    logic [2:0] start;
    logic [2:0] step;
    logic [9:0] mask;
    logic [7:0] total;
  } rowT;

  // code of sample i = start + step*i (mod 8); mask bit i = valid
  localparam rowT ROWS [8] = '{
    '{3'd0, 3'd0, 10'h3FF, 8'd10},
    '{3'd0, 3'd1, 10'h3FF, 8'd10},
    '{3'd7, 3'd0, 10'h3FF, 8'd10},
    '{3'd3, 3'd0, 10'h155, 8'd5},
    '{3'd6, 3'd7, 10'h3EF, 8'd9},
    '{3'd2, 3'd3, 10'h000, 8'd0},
    '{3'd5, 3'd2, 10'h3FF, 8'd10},
    '{3'd1, 3'd1, 10'h000, 8'd0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic [2:0] sampleCode = '0;
  logic [PERIOD_W-1:0] periodLen = PERIOD_W'(LEN);
  logic [2:0] rdAddr = '0;
  logic [BIN_W-1:0] rdData;
  logic [TOTAL_W-1:0] heldTotal;
  logic periodDone, overflowFlag;

  int checks = 0;
  int fails = 0;
  int expPrev [8];
  int expNew [8];
  int totPrev, totNew;
  logic [TOTAL_W-1:0] totSeen;

  always #(CLK_PERIOD/2) clk = ~clk;

  adcCodeTally #(.CODE_W(3), .BIN_W(BIN_W), .PERIOD_W(PERIOD_W)) u0 (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleCode(sampleCode),
    .periodLen(periodLen), .rdAddr(rdAddr), .rdData(rdData),
    .heldTotal(heldTotal), .periodDone(periodDone), .overflowFlag(overflowFlag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic readBin(input int a, output int v);
    rdAddr = 3'(a);
    #1;
    v = int'(rdData);
  endtask

  task automatic doReset(input int len);
    rstN = 1'b0;
    sampleValid = 1'b0;
    periodLen = PERIOD_W'(len);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int v;
    // R1: reset state
    doReset(LEN);
    chk("R1 periodDone", int'(periodDone), 0);
    chk("R1 overflowFlag", int'(overflowFlag), 0);
    chk("R1 heldTotal", int'(heldTotal), 0);
    readBin(3, v); chk("R1 bin3", v, 0);

    // warm-up: first window after reset spans LEN-1 clocks, all invalid
    sampleValid = 1'b0;
    repeat (LEN - 2) @(negedge clk);
    for (int c = 0; c < 8; c++) begin expPrev[c] = 0; expNew[c] = 0; end
    totPrev = 0; totNew = 0;

    // table walk: checks of the previous window run during the next one
    for (int r = 0; r < 8; r++) begin
      for (int i = 0; i < LEN; i++) begin
        @(negedge clk);
        if (i == 1) begin
          chk("R7 done pulse high", int'(periodDone), 1);
          chk("R3 R5 heldTotal", int'(heldTotal), totPrev);
          for (int a = 0; a < 8; a++) begin
            readBin(a, v);
            if (a == 7) chk("R3 derived code7 bin", v, expPrev[7]);
            else        chk("R2 R6 R9 held bin", v, expPrev[a]);
          end
          totSeen = heldTotal;
        end
        if (i == 2) begin
          chk("R7 done pulse one clock", int'(periodDone), 0);
          chk("R5 held stable", int'(heldTotal), int'(totSeen));
        end
        sampleCode  = 3'(ROWS[r].start + ROWS[r].step * 3'(i));
        sampleValid = ROWS[r].mask[i];
        if (sampleValid) begin expNew[sampleCode]++; totNew++; end
      end
      chk("R3 table total", totNew, int'(ROWS[r].total));
      for (int c = 0; c < 8; c++) begin expPrev[c] = expNew[c]; expNew[c] = 0; end
      totPrev = totNew; totNew = 0;
    end

    // R4 R6: periodLen 1 -> every clock is a boundary
    doReset(1);
    sampleCode = 3'd4; sampleValid = 1'b1;
    @(negedge clk);
    chk("R4 len1 done", int'(periodDone), 1);
    sampleCode = 3'd1;
    @(negedge clk);
    sampleValid = 1'b0;
    chk("R4 len1 done again", int'(periodDone), 1);
    chk("R6 len1 total", int'(heldTotal), 1);
    readBin(4, v); chk("R6 len1 bin4", v, 1);
    readBin(1, v); chk("R6 len1 bin1", v, 0);

    // R4: periodLen 0 behaves as every clock
    doReset(0);
    sampleCode = 3'd6; sampleValid = 1'b1;
    @(negedge clk);
    @(negedge clk);
    sampleValid = 1'b0;
    readBin(6, v); chk("R4 len0 bin6", v, 1);

    // R8: saturation of a 6-bit bin and sticky flag
    doReset(80);
    sampleCode = 3'd2; sampleValid = 1'b1;
    repeat (63) @(negedge clk);
    chk("R8 flag before saturation", int'(overflowFlag), 0);
    repeat (17) @(negedge clk);
    chk("R8 done at len 80", int'(periodDone), 1);
    readBin(2, v); chk("R8 saturated bin2", v, 63);
    chk("R8 total keeps counting", int'(heldTotal), 79);
    chk("R8 flag set", int'(overflowFlag), 1);
    sampleValid = 1'b0;
    repeat (90) @(negedge clk);
    chk("R8 flag sticky", int'(overflowFlag), 1);
    readBin(2, v); chk("R2 invalid ignored", v, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule